// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the hazard controller of a single-issue pipeline that issues in program order and lets results complete out of order across five functional units. Each cycle it is offered one decoded instruction, made up of an operation class, a destination register and two source registers. It decides whether that instruction may issue, which units may fetch their operands, which units start executing, and which finished unit may write its result.

Its state is held in two tables. A per-unit status table records what each unit is doing, which registers it names, which unit will produce each of its sources and whether each source is ready. A per-register table records which unit, if any, will produce that register's next value. Execution time is modelled by a countdown timer inside each unit. Register file data, arithmetic and fetch are outside the block. It exposes only strobes and query ports into the two tables.

The unit numbering is fixed. Unit 1 is integer/load-store (class 0, 1 cycle). Units 2 and 3 are multipliers (class 1, 10 cycles each). Unit 4 is add/subtract (class 2, 2 cycles). Unit 5 is divide (class 3, 40 cycles). The value 0 in a producer field means "no producer".

Top module: `scoreboard_ctrl`

## Requirements
- R1: A synchronous reset leaves every unit idle (`unitBusy` = 0) and every register status entry at 0. No grant strobe is active while no instruction is offered.
- R2: An offered instruction issues (`issueAccept` = 1) only when a unit of its class is idle. If all units of that class are busy, issue stalls. Issue is accepted again in the cycle after that unit's write-back cycle.
- R3: An instruction whose destination register already has a pending producer does not issue. It issues in the cycle after that producer writes back.
- R4: On issue, the register status entry for the destination becomes the issuing unit's identifier (1..5), and the unit records its class and destination. Each source is marked ready if its register has no pending producer. Otherwise it is marked not ready and the producer is recorded.
- R5: A unit asserts `readGrant` for exactly one cycle, in the first cycle in which both of its sources are ready, and it reads both sources together. After that cycle both of its ready flags read 0.
- R6: `execStart` pulses in the cycle after `readGrant`. The unit executes for its latency (1, 10, 10, 2, 40 cycles for units 1..5) and becomes eligible to write back in the following cycle.
- R7: On write-back, every waiting source that named the writing unit becomes ready. The unit goes idle. The register status entry for `writeDest` is cleared if it still names that unit.
- R8: A finished unit does not write back while any other waiting unit has a source equal to its destination with that source's ready flag still set.
- R9: When several units are eligible to write back, only the lowest-numbered one is granted. The others write in later cycles.
- R10: When an instruction issues in the same cycle that its source's producer writes back, that source is marked ready at once.
- R11: A multiply instruction takes the lower-numbered idle multiplier. With both multipliers busy, a further multiply stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | An instruction is offered this cycle |
| inClass | input | 2 | Operation class: 0 integer, 1 multiply, 2 add/sub, 3 divide |
| inDest | input | 5 | Destination register |
| inSrc1 | input | 5 | First source register |
| inSrc2 | input | 5 | Second source register |
| qReg | input | 5 | Register selected for status query |
| qUnit | input | 3 | Unit identifier (1..5) selected for query |
| issueAccept | output | 1 | Offered instruction issues at the next edge |
| readGrant | output | 5 | Per unit: operands read this cycle (bit 0 = unit 1) |
| execStart | output | 5 | Per unit: first execution cycle |
| writeGrant | output | 5 | Per unit: result written this cycle |
| writeDest | output | 5 | Destination of the granted write |
| unitBusy | output | 5 | Per unit busy flag |
| unitRdy1 | output | 5 | Per unit first-source ready flag |
| unitRdy2 | output | 5 | Per unit second-source ready flag |
| qProducer | output | 3 | Producer unit recorded for `qReg`, 0 if none |
| qUnitOp | output | 2 | Class held by unit `qUnit` |
| qUnitDest | output | 5 | Destination held by unit `qUnit` |

## Verification
Issue and write-back can fall in the same cycle. An issuing instruction may name, as a source, the very register a finishing unit is writing in that cycle. The bench runs a one-cycle integer operation and offers an add that reads its result in exactly the cycle of the integer write-back. It then checks that the add's source is ready and its operand read is granted in the next cycle, rather than the add waiting for a wake-up that already passed. The bench also provokes a read grant and a blocked write in the same cycle, with the divider reading a register that the adder wants to overwrite. It checks that the write is granted only one cycle after the read.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int NUM_UNITS = 5;
  localparam int UID_W     = 3;

  typedef enum logic [1:0] {
    CL_INT = 2'd0,
    CL_MUL = 2'd1,
    CL_ADD = 2'd2,
    CL_DIV = 2'd3
  } op_class_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_EXEC,
    ST_DONE
  } unit_stage_t;

  typedef struct packed {
    logic                 issue;
    logic [NUM_UNITS-1:0] issueSel;
    logic [NUM_UNITS-1:0] readSel;
    logic [NUM_UNITS-1:0] wbSel;
  } sb_strobe_t;

  function automatic op_class_t unitClass(input int idx);
    case (idx)
      0:       return CL_INT;
      1, 2:    return CL_MUL;
      3:       return CL_ADD;
      default: return CL_DIV;
    endcase
  endfunction

endpackage

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                            inValid,
  input  logic [1:0]                      inClass,
  input  logic [UID_W-1:0]                destProducer,
  input  logic [NUM_UNITS-1:0]            isIdle,
  input  logic [NUM_UNITS-1:0]            isWait,
  input  logic [NUM_UNITS-1:0]            isDone,
  input  logic [NUM_UNITS-1:0]            rdy1,
  input  logic [NUM_UNITS-1:0]            rdy2,
  input  logic [NUM_UNITS-1:0][REG_W-1:0] src1,
  input  logic [NUM_UNITS-1:0][REG_W-1:0] src2,
  input  logic [NUM_UNITS-1:0][REG_W-1:0] dest,
  output sb_strobe_t                      strobe
);

  logic [NUM_UNITS-1:0] freeUnit;
  logic [NUM_UNITS-1:0] pickUnit;
  logic [NUM_UNITS-1:0] warBlock;
  logic [NUM_UNITS-1:0] wbCand;
  logic [NUM_UNITS-1:0] wbPick;
  logic                 foundFree;
  logic                 foundWb;

  // structural check and lowest-index unit of the requested class
  always_comb begin
    freeUnit  = '0;
    pickUnit  = '0;
    foundFree = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      freeUnit[i] = isIdle[i] && (unitClass(i) == op_class_t'(inClass));
      if (freeUnit[i] && !foundFree) begin
        pickUnit[i] = 1'b1;
        foundFree   = 1'b1;
      end
    end
  end

  // a finished unit waits while another waiting unit still needs the old value
  always_comb begin
    warBlock = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      for (int j = 0; j < NUM_UNITS; j++) begin
        if (j != i && isWait[j] &&
            ((src1[j] == dest[i] && rdy1[j]) || (src2[j] == dest[i] && rdy2[j])))
          warBlock[i] = 1'b1;
      end
    end
    wbCand  = isDone & ~warBlock;
    wbPick  = '0;
    foundWb = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (wbCand[i] && !foundWb) begin
        wbPick[i] = 1'b1;
        foundWb   = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.issue    = inValid && foundFree && (destProducer == '0);
    strobe.issueSel = strobe.issue ? pickUnit : '0;
    strobe.readSel  = isWait & rdy1 & rdy2;
    strobe.wbSel    = wbPick;
  end

endmodule

// File: rtl/sb_tables.sv
module sb_tables
  import sb_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40
) (
  input  logic                            clk,
  input  logic                            rst,
  input  sb_strobe_t                      strobe,
  input  logic [1:0]                      inClass,
  input  logic [REG_W-1:0]                inDest,
  input  logic [REG_W-1:0]                inSrc1,
  input  logic [REG_W-1:0]                inSrc2,
  input  logic [REG_W-1:0]                qReg,
  input  logic [UID_W-1:0]                qUnit,
  output logic [UID_W-1:0]                destProducer,
  output logic [NUM_UNITS-1:0]            isIdle,
  output logic [NUM_UNITS-1:0]            isWait,
  output logic [NUM_UNITS-1:0]            isDone,
  output logic [NUM_UNITS-1:0]            rdy1,
  output logic [NUM_UNITS-1:0]            rdy2,
  output logic [NUM_UNITS-1:0][REG_W-1:0] src1,
  output logic [NUM_UNITS-1:0][REG_W-1:0] src2,
  output logic [NUM_UNITS-1:0][REG_W-1:0] dest,
  output logic [NUM_UNITS-1:0]            execStart,
  output logic [REG_W-1:0]                writeDest,
  output logic [UID_W-1:0]                qProducer,
  output logic [1:0]                      qUnitOp,
  output logic [REG_W-1:0]                qUnitDest
);

  localparam int NUM_REGS = 1 << REG_W;
  localparam int LAT_TAB [NUM_UNITS] = '{LAT_INT, LAT_MUL, LAT_MUL, LAT_ADD, LAT_DIV};
  localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ?
                           ((LAT_DIV > LAT_ADD) ? ((LAT_DIV > LAT_INT) ? LAT_DIV : LAT_INT)
                                                : ((LAT_ADD > LAT_INT) ? LAT_ADD : LAT_INT))
                         : ((LAT_MUL > LAT_ADD) ? ((LAT_MUL > LAT_INT) ? LAT_MUL : LAT_INT)
                                                : ((LAT_ADD > LAT_INT) ? LAT_ADD : LAT_INT));
  localparam int TMR_W = $clog2(LAT_MAX + 1);

  unit_stage_t                     stage [NUM_UNITS];
  logic [NUM_UNITS-1:0][1:0]       opTab;
  logic [NUM_UNITS-1:0][UID_W-1:0] prod1;
  logic [NUM_UNITS-1:0][UID_W-1:0] prod2;
  logic [NUM_UNITS-1:0][TMR_W-1:0] tmr;
  logic [UID_W-1:0]                regStat [NUM_REGS];

  logic [UID_W-1:0] wbId;
  logic [UID_W-1:0] issueId;
  logic [UID_W-1:0] newProd1;
  logic [UID_W-1:0] newProd2;

  always_comb begin
    wbId      = '0;
    issueId   = '0;
    writeDest = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (strobe.wbSel[i]) begin
        wbId      = UID_W'(i + 1);
        writeDest = dest[i];
      end
      if (strobe.issueSel[i]) issueId = UID_W'(i + 1);
    end
  end

  // producer lookup for the issuing instruction, with same-cycle write-back bypass
  always_comb begin
    newProd1 = regStat[inSrc1];
    newProd2 = regStat[inSrc2];
    if (wbId != '0 && newProd1 == wbId) newProd1 = '0;
    if (wbId != '0 && newProd2 == wbId) newProd2 = '0;
  end

  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) begin
      isIdle[i]    = (stage[i] == ST_IDLE);
      isWait[i]    = (stage[i] == ST_WAIT);
      isDone[i]    = (stage[i] == ST_DONE);
      execStart[i] = (stage[i] == ST_EXEC) && (tmr[i] == TMR_W'(LAT_TAB[i]));
    end
  end

  assign destProducer = regStat[inDest];
  assign qProducer    = regStat[qReg];

  always_comb begin
    qUnitOp   = '0;
    qUnitDest = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (qUnit == UID_W'(i + 1)) begin
        qUnitOp   = opTab[i];
        qUnitDest = dest[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_UNITS; i++) stage[i] <= ST_IDLE;
      rdy1  <= '0;
      rdy2  <= '0;
      prod1 <= '0;
      prod2 <= '0;
      tmr   <= '0;
      for (int r = 0; r < NUM_REGS; r++) regStat[r] <= '0;
    end else begin
      for (int i = 0; i < NUM_UNITS; i++) begin
        case (stage[i])
          ST_IDLE: begin
            if (strobe.issueSel[i]) begin
              stage[i] <= ST_WAIT;
              opTab[i] <= inClass;
              dest[i]  <= inDest;
              src1[i]  <= inSrc1;
              src2[i]  <= inSrc2;
              prod1[i] <= newProd1;
              prod2[i] <= newProd2;
              rdy1[i]  <= (newProd1 == '0);
              rdy2[i]  <= (newProd2 == '0);
            end
          end
          ST_WAIT: begin
            if (strobe.readSel[i]) begin
              stage[i] <= ST_EXEC;
              tmr[i]   <= TMR_W'(LAT_TAB[i]);
              rdy1[i]  <= 1'b0;
              rdy2[i]  <= 1'b0;
            end else begin
              if (wbId != '0 && prod1[i] == wbId) begin
                prod1[i] <= '0;
                rdy1[i]  <= 1'b1;
              end
              if (wbId != '0 && prod2[i] == wbId) begin
                prod2[i] <= '0;
                rdy2[i]  <= 1'b1;
              end
            end
          end
          ST_EXEC: begin
            tmr[i] <= tmr[i] - 1'b1;
            if (tmr[i] == TMR_W'(1)) stage[i] <= ST_DONE;
          end
          default: begin
            if (strobe.wbSel[i]) stage[i] <= ST_IDLE;
          end
        endcase
      end
      if (wbId != '0 && regStat[writeDest] == wbId) regStat[writeDest] <= '0;
      if (strobe.issue) regStat[inDest] <= issueId;
    end
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_chk
    AST_READY_NO_PRODUCER: assert property (@(posedge clk) disable iff (rst)
      (rdy1[g] |-> prod1[g] == '0) and (rdy2[g] |-> prod2[g] == '0)); // R4
    AST_EXEC_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
      execStart[g] |-> $past(strobe.readSel[g])); // R6
    AST_ISSUE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
      strobe.issueSel[g] |-> stage[g] == ST_IDLE); // R2
    AST_FREE_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
      strobe.wbSel[g] |=> stage[g] == ST_IDLE); // R7
  end

endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
  import sb_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [1:0]           inClass,
  input  logic [REG_W-1:0]     inDest,
  input  logic [REG_W-1:0]     inSrc1,
  input  logic [REG_W-1:0]     inSrc2,
  input  logic [REG_W-1:0]     qReg,
  input  logic [UID_W-1:0]     qUnit,
  output logic                 issueAccept,
  output logic [NUM_UNITS-1:0] readGrant,
  output logic [NUM_UNITS-1:0] execStart,
  output logic [NUM_UNITS-1:0] writeGrant,
  output logic [REG_W-1:0]     writeDest,
  output logic [NUM_UNITS-1:0] unitBusy,
  output logic [NUM_UNITS-1:0] unitRdy1,
  output logic [NUM_UNITS-1:0] unitRdy2,
  output logic [UID_W-1:0]     qProducer,
  output logic [1:0]           qUnitOp,
  output logic [REG_W-1:0]     qUnitDest
);

  sb_strobe_t                      strobe;
  logic [UID_W-1:0]                destProducer;
  logic [NUM_UNITS-1:0]            isIdle;
  logic [NUM_UNITS-1:0]            isWait;
  logic [NUM_UNITS-1:0]            isDone;
  logic [NUM_UNITS-1:0][REG_W-1:0] src1;
  logic [NUM_UNITS-1:0][REG_W-1:0] src2;
  logic [NUM_UNITS-1:0][REG_W-1:0] dest;

  sb_control #(.REG_W(REG_W)) u_ctrl (
    .inValid      (inValid),
    .inClass      (inClass),
    .destProducer (destProducer),
    .isIdle       (isIdle),
    .isWait       (isWait),
    .isDone       (isDone),
    .rdy1         (unitRdy1),
    .rdy2         (unitRdy2),
    .src1         (src1),
    .src2         (src2),
    .dest         (dest),
    .strobe       (strobe)
  );

  sb_tables #(
    .REG_W   (REG_W),
    .LAT_INT (LAT_INT),
    .LAT_MUL (LAT_MUL),
    .LAT_ADD (LAT_ADD),
    .LAT_DIV (LAT_DIV)
  ) u_tab (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .inClass      (inClass),
    .inDest       (inDest),
    .inSrc1       (inSrc1),
    .inSrc2       (inSrc2),
    .qReg         (qReg),
    .qUnit        (qUnit),
    .destProducer (destProducer),
    .isIdle       (isIdle),
    .isWait       (isWait),
    .isDone       (isDone),
    .rdy1         (unitRdy1),
    .rdy2         (unitRdy2),
    .src1         (src1),
    .src2         (src2),
    .dest         (dest),
    .execStart    (execStart),
    .writeDest    (writeDest),
    .qProducer    (qProducer),
    .qUnitOp      (qUnitOp),
    .qUnitDest    (qUnitDest)
  );

  assign issueAccept = strobe.issue;
  assign readGrant   = strobe.readSel;
  assign writeGrant  = strobe.wbSel;
  assign unitBusy    = ~isIdle;

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (rst)
    $countones(writeGrant) <= 1); // R9

endmodule

// File: tb/sim_scoreboard_ctrl.sv
module sim_scoreboard_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] C_INT = 2'd0, C_MUL = 2'd1, C_ADD = 2'd2, C_DIV = 2'd3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [1:0] inClass = '0;
  logic [4:0] inDest = '0, inSrc1 = '0, inSrc2 = '0, qReg = '0;
  logic [2:0] qUnit = '0;
  logic       issueAccept;
  logic [4:0] readGrant, execStart, writeGrant, writeDest, unitBusy, unitRdy1, unitRdy2;
  logic [2:0] qProducer;
  logic [1:0] qUnitOp;
  logic [4:0] qUnitDest;

  int errs = 0;
  int checks = 0;

  scoreboard_ctrl u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inClass(inClass), .inDest(inDest),
    .inSrc1(inSrc1), .inSrc2(inSrc2), .qReg(qReg), .qUnit(qUnit),
    .issueAccept(issueAccept), .readGrant(readGrant), .execStart(execStart),
    .writeGrant(writeGrant), .writeDest(writeDest), .unitBusy(unitBusy),
    .unitRdy1(unitRdy1), .unitRdy2(unitRdy2), .qProducer(qProducer),
    .qUnitOp(qUnitOp), .qUnitDest(qUnitDest)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance to the next cycle: the state is then settled and inputs may be changed
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic offer(input logic [1:0] c, input logic [4:0] d, input logic [4:0] s1,
                       input logic [4:0] s2);
    inValid = 1'b1; inClass = c; inDest = d; inSrc1 = s1; inSrc2 = s2;
    #1;
  endtask

  task automatic noOffer();
    inValid = 1'b0;
    #1;
  endtask

  task automatic doReset();
    rst = 1'b1; inValid = 1'b0;
    repeat (2) tick();
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    noOffer();
    check("R1 busy", unitBusy, 0);
    qReg = 5'd2; #1;
    check("R1 regstat", qProducer, 0);
    check("R1 accept", issueAccept, 0);
    check("R1 readGrant", readGrant, 0);
    check("R1 writeGrant", writeGrant, 0);
  endtask

  // dependency chain with structural, RAW and WAR stalls
  task automatic testChain();
    doReset();
    offer(C_INT, 5'd2, 5'd3, 5'd3);                          // C0
    check("R2 accept int", issueAccept, 1);
    tick();                                                  // C1
    check("R5 read int", readGrant, 5'b00001);
    qReg = 5'd2; #1;
    check("R4 producer", qProducer, 1);
    offer(C_MUL, 5'd0, 5'd2, 5'd4);
    check("R2 accept mul", issueAccept, 1);
    tick();                                                  // C2
    check("R6 exec int", execStart, 5'b00001);
    check("R4 mul src1 waits", unitRdy1[1], 0);
    check("R4 mul src2 ready", unitRdy2[1], 1);
    offer(C_ADD, 5'd8, 5'd6, 5'd2);
    check("R2 accept sub", issueAccept, 1);
    tick();                                                  // C3
    check("R6 int writes", writeGrant, 5'b00001);
    check("R6 int dest", writeDest, 2);
    offer(C_DIV, 5'd10, 5'd0, 5'd6);
    check("R2 accept div", issueAccept, 1);
    tick();                                                  // C4
    check("R7 int idle", unitBusy[0], 0);
    qReg = 5'd2; #1;
    check("R7 regstat cleared", qProducer, 0);
    check("R7 wake readers", readGrant, 5'b01010);
    check("R4 div waits on mul", unitRdy1[4], 0);
    offer(C_ADD, 5'd6, 5'd8, 5'd2);
    check("R2 adder busy stall", issueAccept, 0);
    tick();                                                  // C5
    check("R5 flags cleared", {unitRdy1[3], unitRdy2[3], unitRdy2[1]}, 0);
    check("R5 single read", readGrant, 0);
    tick(); tick();                                          // C7
    check("R6 sub writes", writeGrant, 5'b01000);
    check("R6 sub dest", writeDest, 8);
    check("R2 still busy", issueAccept, 0);
    tick();                                                  // C8
    check("R2 resume", issueAccept, 1);
    tick();                                                  // C9
    noOffer();
    check("R5 add reads", readGrant, 5'b01000);
    for (int k = 10; k < 15; k++) begin
      tick();
      check("R8 add held", writeGrant, 0);
    end
    tick();                                                  // C15
    check("R6 mul writes", writeGrant, 5'b00010);
    check("R6 mul dest", writeDest, 0);
    tick();                                                  // C16
    check("R7 div reads", readGrant, 5'b10000);
    check("R8 held in read cycle", writeGrant, 0);
    tick();                                                  // C17
    check("R8 add released", writeGrant, 5'b01000);
    check("R8 add dest", writeDest, 6);
    for (int k = 18; k < 57; k++) tick();                    // C56
    check("R6 div not yet", writeGrant, 0);
    tick();                                                  // C57
    check("R6 div writes", writeGrant, 5'b10000);
    tick();
    check("R7 all idle", unitBusy, 0);
  endtask

  task automatic testPriority();
    doReset();
    offer(C_ADD, 5'd9, 5'd1, 5'd1);                          // C0
    tick();                                                  // C1
    offer(C_INT, 5'd10, 5'd1, 5'd1);
    qUnit = 3'd4; #1;
    check("R4 unit op", qUnitOp, 2);
    check("R4 unit dest", qUnitDest, 9);
    tick();                                                  // C2
    noOffer();
    tick(); tick();                                          // C4
    check("R9 lowest wins", writeGrant, 5'b00001);
    check("R9 dest", writeDest, 10);
    tick();                                                  // C5
    check("R9 loser later", writeGrant, 5'b01000);
    check("R9 loser dest", writeDest, 9);
  endtask

  task automatic testWaw();
    int waited;
    doReset();
    offer(C_MUL, 5'd7, 5'd1, 5'd2);                          // C0
    tick();                                                  // C1
    qReg = 5'd7;
    offer(C_INT, 5'd7, 5'd3, 5'd3);
    check("R3 producer noted", qProducer, 2);
    check("R3 waw stall", issueAccept, 0);
    waited = 1;
    while (!issueAccept && waited < 40) begin
      tick(); #1;
      waited++;
    end
    check("R3 issue cycle", waited, 13);
    tick();
    noOffer();
  endtask

  task automatic testMulPick();
    doReset();
    offer(C_MUL, 5'd1, 5'd0, 5'd0);
    tick();
    offer(C_MUL, 5'd2, 5'd0, 5'd0);
    check("R11 second mul", issueAccept, 1);
    tick();
    offer(C_MUL, 5'd3, 5'd0, 5'd0);
    check("R11 both busy", unitBusy, 5'b00110);
    check("R11 third stalls", issueAccept, 0);
    qReg = 5'd1; #1;
    check("R11 first unit", qProducer, 2);
    qReg = 5'd2; #1;
    check("R11 second unit", qProducer, 3);
    noOffer();
  endtask

  task automatic testBypass();
    doReset();
    offer(C_INT, 5'd4, 5'd0, 5'd0);                          // C0
    tick(); noOffer();                                       // C1
    tick(); tick();                                          // C3
    check("R10 int writes", writeGrant, 5'b00001);
    offer(C_ADD, 5'd5, 5'd4, 5'd1);
    check("R10 accept", issueAccept, 1);
    tick();                                                  // C4
    noOffer();
    check("R10 src ready", unitRdy1[3], 1);
    check("R10 reads", readGrant, 5'b01000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    testReset();
    testChain();
    testPriority();
    testWaw();
    testMulPick();
    testBypass();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule